// File: doc/BRIEF.md
# Log-Antilog GF(2^8) Byte Multiplier

This block multiplies two bytes in the finite field GF(2^8) that the AES cipher uses. Each byte is read as a polynomial in x, with bit 7 as the x^7 coefficient. Products are reduced by the polynomial x^8+x^4+x^3+x+1 (0x11B). The block does not shift and conditionally XOR. It looks up the discrete logarithm of each operand to the generator 03, adds the two logarithms modulo 255, and turns the sum back into a field element through an antilogarithm table. Both tables are computed by constant functions while the design elaborates, so no table contents are written out.

A caller presents both operands with an input strobe. The product and its own strobe appear on the next clock edge. Field addition is a plain XOR (for example 57 XOR 83 = D4), so the caller does it outside this block. A zero operand has no logarithm. The block detects zero on either operand and forces the product to 00 without using the table result.

Top module: `gf_logmul`

## Requirements
- R1: For nonzero operands a and b, the product equals the polynomial product of a and b reduced modulo 0x11B. Examples: 57*13 = FE, 57*83 = C1, 57*04 = 47, 80*02 = 1B.
- R2: If in_a or in_b is 00 on a strobed cycle, out_prod is 00 after the next clock edge.
- R3: out_vld is high in exactly those cycles that follow a cycle with in_vld high; the latency is one clock.
- R4: While in_vld is low, out_prod keeps its previous value, whatever the operands are.
- R5: While rst is high, the next clock edge sets out_vld to 0 and out_prod to 00.
- R6: Multiplying any operand by 01 returns that operand unchanged.
- R7: When the two logarithms sum to 255 or more, the sum wraps modulo 255. Example: 03 (log 1) times F6 (log 254) gives 01, which is antilog 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand |
| out_vld | output | 1 | Product strobe, one cycle after in_vld |
| out_prod | output | 8 | Registered product |

## Verification
The logarithm table has one entry for each nonzero byte, and the antilogarithm table has one entry for each exponent. A single wrong entry changes the product only for the operand pairs that touch that entry. For that reason the bench compares all 65536 operand pairs with a shift-and-add model, and any corrupted entry shows up on out_prod one cycle after the pair that reaches it is strobed. An error in the modulo-255 wrap affects about half of all nonzero pairs. An error in the zero bypass affects the 511 pairs that contain 00. Both show on the cycle after such a pair. A wrong strobe or hold register shows at the first idle or strobed cycle.

// File: rtl/gf_logmul_pkg.sv
package gf_logmul_pkg;
    localparam int          GF_W     = 8;
    localparam int          GF_SIZE  = 1 << GF_W;
    localparam int          GF_ORDER = GF_SIZE - 1;
    localparam logic [8:0]  GF_POLY  = 9'h11B;
    localparam logic [7:0]  GF_GEN   = 8'h03;

    typedef logic [GF_W-1:0] gf_t;

    // multiply by x, reduce by the field polynomial
    function automatic gf_t gf_xtime(gf_t v);
        gf_t sh;
        sh = gf_t'({v[GF_W-2:0], 1'b0});
        return v[GF_W-1] ? (sh ^ GF_POLY[GF_W-1:0]) : sh;
    endfunction

    // multiply by the generator 03 = x + 1
    function automatic gf_t gf_step(gf_t v);
        return gf_xtime(v) ^ v;
    endfunction

    // generator raised to power e
    function automatic gf_t gf_alog_of(int e);
        gf_t p;
        p = gf_t'(1);
        for (int i = 0; i < e; i++) p = gf_step(p);
        return p;
    endfunction

    // exponent of v to the generator; zero maps to 0 (never used)
    function automatic gf_t gf_log_of(int v);
        gf_t p;
        gf_t r;
        p = gf_t'(1);
        r = '0;
        for (int e = 0; e < GF_ORDER; e++) begin
            if (p == gf_t'(v)) r = gf_t'(e);
            p = gf_step(p);
        end
        return r;
    endfunction
endpackage

// File: rtl/gf_tab_rom.sv
module gf_tab_rom
    import gf_logmul_pkg::*;
#(
    parameter bit IS_LOG = 1'b1
) (
    input  gf_t addr,
    output gf_t data
);
    gf_t tab [GF_SIZE];

    for (genvar i = 0; i < GF_SIZE; i++) begin : g_ent
        if (IS_LOG) begin : g_log
            assign tab[i] = gf_log_of(i);
        end else begin : g_alog
            assign tab[i] = gf_alog_of(i);
        end
    end

    assign data = tab[addr];
endmodule

// File: rtl/gf_exp_add.sv
module gf_exp_add
    import gf_logmul_pkg::*;
(
    input  gf_t la,
    input  gf_t lb,
    output gf_t exp_o
);
    localparam logic [GF_W:0] ORD = (GF_W+1)'(GF_ORDER);

    logic [GF_W:0] sum;
    logic [GF_W:0] red;

    assign sum   = {1'b0, la} + {1'b0, lb};
    assign red   = sum - ORD;
    assign exp_o = (sum >= ORD) ? red[GF_W-1:0] : sum[GF_W-1:0];
endmodule

// File: rtl/gf_logmul.sv
module gf_logmul
    import gf_logmul_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic [7:0] in_a,
    input  logic [7:0] in_b,
    output logic       out_vld,
    output logic [7:0] out_prod
);
    gf_t la, lb, exp_sum, alog_val, prod_nxt;
    logic zero_hit;

    gf_tab_rom #(.IS_LOG(1'b1)) u_log_a (.addr(in_a),    .data(la));
    gf_tab_rom #(.IS_LOG(1'b1)) u_log_b (.addr(in_b),    .data(lb));
    gf_exp_add                  u_add   (.la(la), .lb(lb), .exp_o(exp_sum));
    gf_tab_rom #(.IS_LOG(1'b0)) u_alog  (.addr(exp_sum), .data(alog_val));

    always_comb begin
        zero_hit = (in_a == '0) || (in_b == '0);
        prod_nxt = zero_hit ? '0 : alog_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_prod <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_prod <= prod_nxt;
        end
    end
endmodule

// File: rtl/gf_logmul_chk.sv
module gf_logmul_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_vld,
    input logic [7:0] in_a,
    input logic [7:0] in_b,
    input logic       out_vld,
    input logic [7:0] out_prod,
    input logic [7:0] exp_sum
);
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R3
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R3
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (in_a == 8'h00 || in_b == 8'h00)) |=> (out_prod == 8'h00)); // R2
    AST_HOLD_PRODUCT: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(out_prod)); // R4
    AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_b == 8'h01) |=> (out_prod == $past(in_a))); // R6
    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (rst) exp_sum != 8'hFF); // R7
    AST_NONZERO_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_a != 8'h00 && in_b != 8'h00) |=> (out_prod != 8'h00)); // R1
endmodule

bind gf_logmul gf_logmul_chk u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .out_vld(out_vld), .out_prod(out_prod), .exp_sum(exp_sum)
);

// File: tb/gf_logmul_tb.sv
`timescale 1ns/1ps
module gf_logmul_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [7:0] in_a = '0;
    logic [7:0] in_b = '0;
    logic       out_vld;
    logic [7:0] out_prod;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gf_logmul u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .out_vld(out_vld), .out_prod(out_prod)
    );

    // {a, b, expected}
    localparam logic [23:0] VEC [12] = '{
        {8'h57, 8'h13, 8'hFE},   // R1
        {8'h57, 8'h83, 8'hC1},   // R1
        {8'h57, 8'h04, 8'h47},   // R1
        {8'h80, 8'h02, 8'h1B},   // R1
        {8'h02, 8'h80, 8'h1B},   // R1
        {8'h57, 8'h02, 8'hAE},   // R1
        {8'h03, 8'hF6, 8'h01},   // R7
        {8'hF6, 8'h03, 8'h01},   // R7
        {8'h00, 8'h57, 8'h00},   // R2
        {8'h57, 8'h00, 8'h00},   // R2
        {8'hAB, 8'h01, 8'hAB},   // R6
        {8'h01, 8'h01, 8'h01}    // R6
    };

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = '0;
        for (int i = 0; i < 8; i++) begin
            if (b[0]) p ^= a;
            a = a[7] ? ({a[6:0], 1'b0} ^ 8'h1B) : {a[6:0], 1'b0};
            b = b >> 1;
        end
        return p;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic apply(logic v, logic [7:0] a, logic [7:0] b);
        @(negedge clk);
        in_vld = v; in_a = a; in_b = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R5 vld", {7'b0, out_vld}, 8'h00);
        check("R5 prod", out_prod, 8'h00);
        @(negedge clk); rst = 1'b0;

        foreach (VEC[i]) begin
            apply(1'b1, VEC[i][23:16], VEC[i][15:8]);
            check("R1/R2/R6/R7 vector", out_prod, VEC[i][7:0]);
            check("R3 vld", {7'b0, out_vld}, 8'h01);
        end

        // R4: idle cycles with changing operands keep the product
        apply(1'b1, 8'h57, 8'h83);
        held = out_prod;
        apply(1'b0, 8'h12, 8'h34);
        check("R4 hold", out_prod, held);
        check("R3 idle vld", {7'b0, out_vld}, 8'h00);
        apply(1'b0, 8'h00, 8'h99);
        check("R4 hold zero operand", out_prod, held);

        // exhaustive sweep against shift-and-add model
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(1'b1, 8'(a), 8'(b));
                check((a == 0 || b == 0) ? "R2 sweep" : "R1 sweep",
                      out_prod, ref_mul(8'(a), 8'(b)));
            end
        end

        // R5: reset mid-run clears outputs
        @(negedge clk); rst = 1'b1; in_vld = 1'b1; in_a = 8'h57; in_b = 8'h13;
        @(posedge clk); #1;
        check("R5 mid vld", {7'b0, out_vld}, 8'h00);
        check("R5 mid prod", out_prod, 8'h00);
        @(negedge clk); rst = 1'b0; in_vld = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule